// File: doc/BRIEF.md
# GPIO Bank with Line Interrupts

This block controls a bank of general-purpose pad lines from a small memory-mapped register port. Each line can be an output or an input.

- **Outputs.** An output line drives a latched value onto its pad. It can optionally blink, which means toggling at a rate set by a prescaler.
- **Inputs.** An input line is sampled through a two-flop synchronizer. It is then optionally inverted by a per-line polarity bit. The resulting corrected value is readable as the data-in view.

The corrected input also feeds an interrupt unit, which has two kinds of source per line:

- **Level source.** This has no storage and follows the corrected line.
- **Edge source.** This latches a 0-to-1 transition of the corrected line into a cause register. Setting the polarity bit therefore turns it into falling-edge detection.

Each source has its own mask. The masked terms of a line are ORed into that line's pending bit. Pending bits are then ORed per group of eight lines onto one summary interrupt output per group. Software acknowledges an edge by writing the cause register with zeros in the bits to be cleared.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the direction register reads all ones, every line is an input, and `pad_oe` is zero. Every other register reads zero and `irq_summary` is zero.
- R2: Registers are selected by word address on `reg_addr`:
  - 0x00 output latch
  - 0x04 direction
  - 0x08 blink enable
  - 0x0C input polarity
  - 0x10 data-in
  - 0x14 edge cause
  - 0x18 edge mask
  - 0x1C level mask

  The output latch, direction, blink, polarity and both mask registers read back the last value written.
- R3: A direction bit of 0 makes the line an output: `pad_oe` is set for it and `pad_out` carries the latch value. A direction bit of 1 makes it an input with `pad_oe` clear.
- R4: Data-in reads the pad value XOR the polarity register, two clock edges after the pad changes.
- R5: A line's level term is its corrected input AND its level-mask bit. It has no memory and drops as soon as the corrected input drops.
- R6: Bit k of `irq_summary` is the OR of the pending bits of lines 8k to 8k+7. A line's pending bit is its masked level term OR its masked edge term.
- R7: A 0-to-1 change of the corrected input sets the line's cause bit one edge after data-in shows it. The bit stays set after the input returns.
- R8: A write to the edge cause clears each bit written as 0 and keeps each bit written as 1.
- R9: With the polarity bit set, a falling pad edge sets the cause bit and a rising pad edge does not.
- R10: Writing zeros to the edge cause, edge mask and level mask clears all causes and holds `irq_summary` at zero whatever the pads do.
- R11: A new edge in the same cycle as a clearing cause write leaves its cause bit set.
- R12: On an output line with its blink bit set, `pad_out` toggles once every `BLINK_DIV` cycles. Blink has no effect on lines without the bit or on input lines.
- R13: Writes to data-in are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Byte address of the register word |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | LINES | Write data |
| reg_rdata | output | LINES | Read data for `reg_addr`, combinational |
| pad_in | input | LINES | Pad input levels, asynchronous |
| pad_out | output | LINES | Pad output values |
| pad_oe | output | LINES | Pad output enables, 1 drives the pad |
| irq_summary | output | LINES/8 | One interrupt per group of eight lines |

## Verification

**One-hot pad sweep over all 32 lines.** This is run with level masks and then with edge masks. It separates the group routing of each line onto its summary bit from cross-line leakage. It also separates a level term, which drops with the pad, from an edge cause, which stays latched.

**Polarity patterns.** Mixed pad and polarity patterns distinguish XOR inversion from a plain copy. Setting polarity on a low pad shows that inversion itself creates an edge. After that, rising and falling pad transitions confirm that only the falling one latches.

**Acknowledge and clear.** All-ones and single-zero acknowledge words separate write-zero-to-clear from other write semantics. A clearing write issued on the same edge as an incoming transition shows which of the two wins.

**Blink counting.** Counting `pad_out` toggles over a fixed window checks the blink rate. It also shows that blink stays off on lines that are inputs or have no blink bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 5;
  typedef enum logic [ADDR_W-1:0] {
    RA_OUT   = 5'h00,
    RA_DIR   = 5'h04,
    RA_BLINK = 5'h08,
    RA_POL   = 5'h0C,
    RA_DIN   = 5'h10,
    RA_CAUSE = 5'h14,
    RA_EMASK = 5'h18,
    RA_LMASK = 5'h1C
  } reg_addr_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/gpio_bank_blink.sv
module gpio_bank_blink #(
  parameter int DIV = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    phase_d = wrap ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R12
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int LINES = 32,
  parameter int GROUP = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES-1:0]         din,
  input  logic                     cause_we,
  input  logic                     emask_we,
  input  logic                     lmask_we,
  input  logic [LINES-1:0]         wdata,
  output logic [LINES-1:0]         cause,
  output logic [LINES-1:0]         emask,
  output logic [LINES-1:0]         lmask,
  output logic [LINES/GROUP-1:0]   summary
);
  localparam int GROUPS = LINES / GROUP;

  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] cause_q, cause_d;
  logic [LINES-1:0] emask_q, emask_d;
  logic [LINES-1:0] lmask_q, lmask_d;
  logic [LINES-1:0] rise;
  logic [LINES-1:0] pending;

  assign rise = din & ~prev_q;

  always_comb begin
    cause_d = cause_we ? (cause_q & wdata) : cause_q;
    cause_d = cause_d | rise;
    emask_d = emask_we ? wdata : emask_q;
    lmask_d = lmask_we ? wdata : lmask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      cause_q <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else begin
      prev_q  <= din;
      cause_q <= cause_d;
      emask_q <= emask_d;
      lmask_q <= lmask_d;
    end
  end

  assign pending = (din & lmask_q) | (cause_q & emask_q);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign summary[g] = |pending[g*GROUP +: GROUP];
  end

  assign cause = cause_q;
  assign emask = emask_q;
  assign lmask = lmask_q;

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_we |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R7
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((cause_q & $past(rise)) == $past(rise))); // R11
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (emask_q == '0 && lmask_q == '0) |-> (summary == '0)); // R10
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int LINES     = 32,
  parameter int GROUP     = 8,
  parameter int BLINK_DIV = 1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_we,
  input  logic [LINES-1:0]       reg_wdata,
  output logic [LINES-1:0]       reg_rdata,
  input  logic [LINES-1:0]       pad_in,
  output logic [LINES-1:0]       pad_out,
  output logic [LINES-1:0]       pad_oe,
  output logic [LINES/GROUP-1:0] irq_summary
);
  logic [LINES-1:0] out_q, out_d;
  logic [LINES-1:0] dir_q, dir_d;
  logic [LINES-1:0] blink_q, blink_d;
  logic [LINES-1:0] pol_q, pol_d;
  logic [LINES-1:0] pad_sync, din;
  logic [LINES-1:0] cause, emask, lmask;
  logic             phase;
  reg_addr_e        sel;

  assign sel = reg_addr_e'(reg_addr);

  always_comb begin
    out_d   = out_q;
    dir_d   = dir_q;
    blink_d = blink_q;
    pol_d   = pol_q;
    if (reg_we) begin
      case (sel)
        RA_OUT:   out_d   = reg_wdata;
        RA_DIR:   dir_d   = reg_wdata;
        RA_BLINK: blink_d = reg_wdata;
        RA_POL:   pol_d   = reg_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
    end else begin
      out_q   <= out_d;
      dir_q   <= dir_d;
      blink_q <= blink_d;
      pol_q   <= pol_d;
    end
  end

  gpio_bank_sync #(.W(LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_sync)
  );

  assign din = pad_sync ^ pol_q;

  gpio_bank_blink #(.DIV(BLINK_DIV)) u_blink (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase)
  );

  gpio_bank_irq #(.LINES(LINES), .GROUP(GROUP)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .cause_we (reg_we && sel == RA_CAUSE),
    .emask_we (reg_we && sel == RA_EMASK),
    .lmask_we (reg_we && sel == RA_LMASK),
    .wdata    (reg_wdata),
    .cause    (cause),
    .emask    (emask),
    .lmask    (lmask),
    .summary  (irq_summary)
  );

  assign pad_oe  = ~dir_q;
  assign pad_out = out_q ^ (blink_q & ~dir_q & {LINES{phase}});

  always_comb begin
    case (sel)
      RA_OUT:   reg_rdata = out_q;
      RA_DIR:   reg_rdata = dir_q;
      RA_BLINK: reg_rdata = blink_q;
      RA_POL:   reg_rdata = pol_q;
      RA_DIN:   reg_rdata = din;
      RA_CAUSE: reg_rdata = cause;
      RA_EMASK: reg_rdata = emask;
      RA_LMASK: reg_rdata = lmask;
      default:  reg_rdata = '0;
    endcase
  end

  AST_STEADY_NO_BLINK: assert property (@(posedge clk) disable iff (!rst_n)
    ((blink_q & ~dir_q) == '0 && $stable(out_q)) |-> $stable(pad_out)); // R12
  AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & dir_q) == '0)); // R3
endmodule

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
  localparam int DIV = 4;
  localparam logic [4:0] A_OUT = 5'h00, A_DIR = 5'h04, A_BLK = 5'h08,
    A_POL = 5'h0C, A_DIN = 5'h10, A_CAU = 5'h14, A_EMK = 5'h18, A_LMK = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic [3:0]  irq_summary;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_bank #(.LINES(32), .GROUP(8), .BLINK_DIV(DIV)) u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_summary(irq_summary));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] grp(input logic [31:0] p);
    logic [3:0] g;
    for (int k = 0; k < 4; k++) g[k] = |p[k*8 +: 8];
    return g;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pats [4];
    int tog0, tog1, tog2;
    logic [31:0] last;
    pats[0] = 32'h0000_0000; pats[1] = 32'hA5C3_0F96;
    pats[2] = 32'hFFFF_FFFF; pats[3] = 32'h1234_8001;

    step(3); rst_n = 1'b1; step(1);
    // R1 reset state
    rd(A_DIR, v); chk("R1 dir", v, 32'hFFFF_FFFF);
    rd(A_OUT, v); chk("R1 out", v, 0);
    rd(A_BLK, v); chk("R1 blink", v, 0);
    rd(A_POL, v); chk("R1 pol", v, 0);
    rd(A_CAU, v); chk("R1 cause", v, 0);
    rd(A_EMK, v); chk("R1 emask", v, 0);
    rd(A_LMK, v); chk("R1 lmask", v, 0);
    chk("R1 oe", pad_oe, 0);
    chk("R1 irq", {28'd0, irq_summary}, 0);

    // R2 readback, R3 direction and output
    foreach (pats[i]) begin
      wr(A_OUT, pats[i]); wr(A_DIR, ~pats[(i+1)%4]); wr(A_BLK, 0);
      wr(A_EMK, pats[(i+2)%4]); wr(A_LMK, pats[(i+3)%4]);
      rd(A_OUT, v); chk("R2 out", v, pats[i]);
      rd(A_DIR, v); chk("R2 dir", v, ~pats[(i+1)%4]);
      rd(A_EMK, v); chk("R2 emask", v, pats[(i+2)%4]);
      rd(A_LMK, v); chk("R2 lmask", v, pats[(i+3)%4]);
      chk("R3 oe", pad_oe, pats[(i+1)%4]);
      chk("R3 pad_out", pad_out, pats[i]);
    end
    wr(A_EMK, 0); wr(A_LMK, 0); wr(A_DIR, 32'hFFFF_FFFF); wr(A_OUT, 0);

    // R4 polarity on data-in; R13 data-in not writable
    foreach (pats[i]) begin
      wr(A_POL, pats[(i+1)%4]); pad_in = pats[i]; step(3);
      rd(A_POL, v); chk("R2 pol", v, pats[(i+1)%4]);
      rd(A_DIN, v); chk("R4 din", v, pats[i] ^ pats[(i+1)%4]);
    end
    wr(A_POL, 0); pad_in = 0; step(3);
    wr(A_DIN, 32'hFFFF_FFFF); rd(A_DIN, v); chk("R13 din write ignored", v, 0);
    wr(A_CAU, 0);

    // R5 R6 level sweep
    wr(A_LMK, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      pad_in = 32'd1 << i; step(3);
      chk("R6 level group", {28'd0, irq_summary}, {28'd0, grp(32'd1 << i)});
      wr(A_LMK, ~(32'd1 << i));
      chk("R5 level masked", {28'd0, irq_summary}, 0);
      wr(A_LMK, 32'hFFFF_FFFF);
      pad_in = 0; step(3);
      chk("R5 level follows", {28'd0, irq_summary}, 0);
    end
    wr(A_LMK, 0); wr(A_CAU, 0);

    // R7 R6 edge sweep
    wr(A_EMK, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      pad_in = 32'd1 << i; step(4);
      rd(A_CAU, v); chk("R7 edge latch", v, 32'd1 << i);
      chk("R6 edge group", {28'd0, irq_summary}, {28'd0, grp(32'd1 << i)});
      pad_in = 0; step(4);
      rd(A_CAU, v); chk("R7 edge held", v, 32'd1 << i);
      wr(A_CAU, ~(32'd1 << i));
      rd(A_CAU, v); chk("R8 ack one", v, 0);
    end

    // R8 selective acknowledge
    pad_in = 32'hFFFF_FFFF; step(4);
    wr(A_CAU, 32'hFFFF_FFEF); rd(A_CAU, v); chk("R8 ack keeps ones", v, 32'hFFFF_FFEF);
    wr(A_CAU, 32'h0F0F_0F0F); rd(A_CAU, v); chk("R8 ack mixed", v, 32'h0F0F_0F0F);
    pad_in = 0; step(4); wr(A_CAU, 0);

    // R9 falling edge via polarity
    wr(A_POL, 32'h0000_0100); step(4);
    rd(A_CAU, v); chk("R9 pol flip edge", v, 32'h0000_0100);
    wr(A_CAU, 0);
    pad_in = 32'h0000_0100; step(4);
    rd(A_CAU, v); chk("R9 rising ignored", v, 0);
    pad_in = 0; step(4);
    rd(A_CAU, v); chk("R9 falling latched", v, 32'h0000_0100);
    wr(A_POL, 0); step(4); wr(A_CAU, 0);

    // R10 clear all
    wr(A_LMK, 32'hFFFF_FFFF); pad_in = 32'hFFFF_FFFF; step(4);
    chk("R10 pre", {28'd0, irq_summary}, 32'hF);
    wr(A_CAU, 0); wr(A_EMK, 0); wr(A_LMK, 0);
    rd(A_CAU, v); chk("R10 cause clear", v, 0);
    chk("R10 irq quiet", {28'd0, irq_summary}, 0);
    pad_in = 0; step(4); pad_in = 32'h8001_8001; step(4);
    chk("R10 irq stays quiet", {28'd0, irq_summary}, 0);
    pad_in = 0; step(4); wr(A_CAU, 0);

    // R11 edge same cycle as clearing write
    pad_in = 32'h0000_0008; step(2);
    wr(A_CAU, 0);
    rd(A_CAU, v); chk("R11 edge wins", v, 32'h0000_0008);
    pad_in = 0; step(4); wr(A_CAU, 0);

    // R12 blink
    wr(A_OUT, 32'h3); wr(A_DIR, ~32'h3); wr(A_BLK, 32'h5);
    chk("R3 oe outputs", pad_oe, 32'h3);
    last = pad_out; tog0 = 0; tog1 = 0; tog2 = 0;
    for (int c = 0; c < 8*DIV; c++) begin
      step(1);
      if (pad_out[0] != last[0]) tog0++;
      if (pad_out[1] != last[1]) tog1++;
      if (pad_out[2] != last[2]) tog2++;
      last = pad_out;
    end
    chk("R12 blink toggles", tog0, 8);
    chk("R12 no blink bit steady", tog1, 0);
    chk("R12 input line steady", tog2, 0);
    chk("R12 steady value", {31'd0, pad_out[1]}, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule